// File: doc/BRIEF.md
# Debug Control Data Register with Reset Acknowledge Gating

This block is the control data register behind a JTAG TAP. It spans two clock domains. On Capture-DR it loads a 32-bit word into a shift chain. That word holds a sticky processor-reset flag, two read-only processor status bits and a small set of writable control bits. On Shift-DR it moves the chain one bit per TCK from TDI toward TDO, least significant bit first. On Update-DR it commits the writable bits. The committed bits are held in the TCK domain as a shadow, and the shadow answers every readback. A request/acknowledge handshake copies the shadow into the processor clock domain, where it drives the control outputs.

The sticky flag sits in the top bit. It is forced to 1 while the processor is in reset and stays at 1 after reset is removed. The only way to clear it is a scan that writes 0 into that bit. While the flag reads 1, an Update-DR that leaves the top bit at 1 is discarded as a whole. The host must first acknowledge the reset before any control write lands.

Because the shadow lives in the TCK domain, a written value reads back on the very next Capture-DR, even when no idle cycle separates the scans. The host can therefore confirm that a write was taken.

Top module: `dbg_ctl_dr`

## Requirements
- R1: After TAP reset (trst_n low) with the processor reset released, the first capture reads bit 31 = 1 and writable bits [2:0] = 0. Bit 5 mirrors lp_i and bit 4 mirrors dm_i.
- R2: Bit 31, the reset flag, reads 1 whenever the synchronised processor reset is active. The flag stays at 1 after reset is released. It is cleared only by an accepted Update-DR with shifted bit 31 = 0. Writing 1 never sets it.
- R3: An Update-DR while the flag is 1 and shifted bit 31 is 1 changes nothing. The flag and the writable bits keep their values.
- R4: An accepted write to writable bits [2:0] reads back on the next Capture-DR, including when Capture-DR follows Update-DR on the next TCK. Bit 0 is the interrupt request, bit 1 the probe enable and bit 2 the debug vector location.
- R5: The writable bits reach ctl_o in the processor clock domain within a bounded number of cycles through a toggle handshake. Processor reset drives ctl_o to 0.
- R6: Capture-DR loads bit 4 from the synchronised dm_i and bit 5 from the synchronised lp_i. Writes to bits 4 and 5 have no effect.
- R7: After Capture-DR, tdo presents captured bit 0 first. Each Shift-DR cycle moves the chain one position toward bit 0, and tdi enters at bit 31.
- R8: Bits 30..6 and 3 always capture as 0, whatever was written to them.
- R9: While the processor reset is active, the writable bits read 0 and a write to them is not retained, even when the write clears bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | TAP reset, active low, asynchronous |
| sel_i | input | 1 | Instruction register selects this data register |
| capture_dr_i | input | 1 | TAP in Capture-DR |
| shift_dr_i | input | 1 | TAP in Shift-DR |
| update_dr_i | input | 1 | TAP in Update-DR |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| cpu_clk | input | 1 | Processor clock |
| cpu_rst_n | input | 1 | Processor reset, active low |
| dm_i | input | 1 | Processor is in debug mode (processor domain) |
| lp_i | input | 1 | Processor is in low-power state (processor domain) |
| ctl_o | output | 3 | Committed writable bits, processor domain |

## Verification
A vector table drives a chain of back-to-back scans, each capturing the result of the previous write. The table covers four cases: a write refused because the flag is set and not cleared, a write that clears the flag, a write of 1 into an already clear flag, and words full of ones or zeros in the unimplemented positions. Together these separate the update gate from plain storage and from masking. Directed scans then assert processor reset around clearing writes. They show the flag staying set during reset and remaining sticky after it. They also show that the writable bits are wiped. Changed status inputs and waits on ctl_o confirm the status capture and the crossing into the processor domain.

// File: rtl/dbg_dr_pkg.sv
`timescale 1ns/1ps
package dbg_dr_pkg;
   // Default layout of the control data register
   localparam int DEF_DR_W   = 32;
   localparam int DEF_CTL_W  = 3;
   localparam int DEF_DM_POS = 4;
   localparam int DEF_LP_POS = 5;
   localparam int DEF_SYNC_N = 2;

   // Writable bit roles
   typedef enum int {
      CTL_IRQ   = 0,
      CTL_PROBE = 1,
      CTL_VEC   = 2
   } ctl_bit_e;
endpackage

// File: rtl/dbg_sync.sv
`timescale 1ns/1ps
module dbg_sync #(
   parameter int           W       = 1,
   parameter int           STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dbg_sync: STAGES must be at least 2");
   end

   for (genvar k = 0; k < STAGES; k++) begin : g_stg
      logic [W-1:0] r;
      if (k == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stg[k-1].r;
      end
   end

   assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/dbg_cdc_push.sv
`timescale 1ns/1ps
module dbg_cdc_push #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         src_clk,
   input  logic         src_rst_n,
   input  logic [W-1:0] src_data,
   input  logic         dst_clk,
   input  logic         dst_rst_n,
   output logic [W-1:0] dst_data
);
   logic         req_q, ack_q, req_s, ack_s;
   logic [W-1:0] hold_q;

   // source side: launch a new value only when the last one was taken
   always_ff @(posedge src_clk or negedge src_rst_n)
      if (!src_rst_n) begin
         req_q  <= 1'b0;
         hold_q <= '0;
      end else if ((req_q == ack_s) && (hold_q != src_data)) begin
         hold_q <= src_data;
         req_q  <= ~req_q;
      end

   dbg_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk(dst_clk), .rst_n(dst_rst_n), .d(req_q), .q(req_s));

   dbg_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk(src_clk), .rst_n(src_rst_n), .d(ack_q), .q(ack_s));

   // destination side: sample the held word once the request toggles
   always_ff @(posedge dst_clk or negedge dst_rst_n)
      if (!dst_rst_n) begin
         ack_q    <= 1'b0;
         dst_data <= '0;
      end else if (req_s != ack_q) begin
         dst_data <= hold_q;
         ack_q    <= req_s;
      end

   // R5
   hold_stable_chk: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      (req_q != ack_s) |=> $stable(hold_q));

   // R5
   dst_quiet_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      (req_s == ack_q) |=> $stable(dst_data));
endmodule

// File: rtl/dbg_ctl_dr.sv
`timescale 1ns/1ps
module dbg_ctl_dr
   import dbg_dr_pkg::*;
#(
   parameter int DR_W   = DEF_DR_W,
   parameter int CTL_W  = DEF_CTL_W,
   parameter int DM_POS = DEF_DM_POS,
   parameter int LP_POS = DEF_LP_POS,
   parameter int SYNC_N = DEF_SYNC_N
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             sel_i,
   input  logic             capture_dr_i,
   input  logic             shift_dr_i,
   input  logic             update_dr_i,
   input  logic             tdi,
   output logic             tdo,
   input  logic             cpu_clk,
   input  logic             cpu_rst_n,
   input  logic             dm_i,
   input  logic             lp_i,
   output logic [CTL_W-1:0] ctl_o
);
   localparam int FLAG_POS = DR_W - 1;
   localparam logic [DR_W-1:0] ONE = DR_W'(1);
   localparam logic [DR_W-1:0] IMPL_MASK = ((ONE << CTL_W) - ONE) | (ONE << DM_POS)
                                         | (ONE << LP_POS) | (ONE << FLAG_POS);

   if (CTL_W < 1 || DM_POS < CTL_W || LP_POS < CTL_W || DM_POS == LP_POS ||
       DM_POS >= FLAG_POS || LP_POS >= FLAG_POS) begin : g_bad_cfg
      $error("dbg_ctl_dr: field layout overlaps or exceeds the register");
   end

   logic             rst_s;
   logic [1:0]       stat_s;
   logic [DR_W-1:0]  sr_q, cap_w;
   logic             flag_q;
   logic [CTL_W-1:0] shad_q;
   logic             upd_hit, upd_ok;

   // processor reset level into TCK domain (treated as active after TAP reset)
   dbg_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_rst_sync (
      .clk(tck), .rst_n(trst_n), .d(~cpu_rst_n), .q(rst_s));

   // status bits into TCK domain
   dbg_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(2'b00)) u_stat_sync (
      .clk(tck), .rst_n(trst_n), .d({lp_i, dm_i}), .q(stat_s));

   always_comb begin
      cap_w               = '0;
      cap_w[CTL_W-1:0]    = shad_q;
      cap_w[DM_POS]       = stat_s[0];
      cap_w[LP_POS]       = stat_s[1];
      cap_w[FLAG_POS]     = flag_q;
   end

   assign upd_hit = sel_i & update_dr_i;
   assign upd_ok  = upd_hit & (~flag_q | ~sr_q[FLAG_POS]);

   always_ff @(posedge tck or negedge trst_n)
      if (!trst_n)                   sr_q <= '0;
      else if (sel_i & capture_dr_i) sr_q <= cap_w;
      else if (sel_i & shift_dr_i)   sr_q <= {tdi, sr_q[DR_W-1:1]};

   always_ff @(posedge tck or negedge trst_n)
      if (!trst_n)      flag_q <= 1'b1;
      else if (rst_s)   flag_q <= 1'b1;
      else if (upd_hit) flag_q <= flag_q & sr_q[FLAG_POS];

   always_ff @(posedge tck or negedge trst_n)
      if (!trst_n)     shad_q <= '0;
      else if (rst_s)  shad_q <= '0;
      else if (upd_ok) shad_q <= sr_q[CTL_W-1:0];

   assign tdo = sr_q[0];

   dbg_cdc_push #(.W(CTL_W), .STAGES(SYNC_N)) u_push (
      .src_clk(tck), .src_rst_n(trst_n), .src_data(shad_q),
      .dst_clk(cpu_clk), .dst_rst_n(cpu_rst_n), .dst_data(ctl_o));

   // R2
   flag_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
      rst_s |=> flag_q);

   // R2
   flag_rise_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(flag_q) |-> $past(rst_s));

   // R3
   gate_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (upd_hit && flag_q && sr_q[FLAG_POS] && !rst_s) |=> ($stable(shad_q) && flag_q));

   // R4
   readback_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (upd_ok && !rst_s) |=> (shad_q == $past(sr_q[CTL_W-1:0])));

   // R8
   unused_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (sel_i && capture_dr_i) |=> ((sr_q & ~IMPL_MASK) == '0));

   // R9
   reset_wipe_chk: assert property (@(posedge tck) disable iff (!trst_n)
      rst_s |=> (shad_q == '0));
endmodule

// File: tb/dbg_ctl_dr_tb.sv
`timescale 1ns/1ps
module dbg_ctl_dr_tb;
   logic tck = 1'b0, cpu_clk = 1'b0;
   logic trst_n, sel, cap_dr, sh_dr, up_dr, tdi, tdo;
   logic cpu_rst_n, dm, lp;
   logic [2:0] ctl;
   int n_chk = 0, n_bad = 0;
   logic done = 1'b0;

   always #2.5 tck = ~tck;
   always #3.5 cpu_clk = ~cpu_clk;

   dbg_ctl_dr u_dut (
      .tck(tck), .trst_n(trst_n), .sel_i(sel), .capture_dr_i(cap_dr),
      .shift_dr_i(sh_dr), .update_dr_i(up_dr), .tdi(tdi), .tdo(tdo),
      .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .dm_i(dm), .lp_i(lp),
      .ctl_o(ctl));

   typedef struct packed { logic [31:0] wr; logic [31:0] rd; } vec_t;
   // rd = word captured by the scan after wr is applied (dm=0, lp=1 -> bit 5 set)
   localparam int NV = 6;
   localparam vec_t TBL [NV] = '{
      '{32'h8000_0007, 32'h8000_0020},  // R3 refused: flag set, bit 31 kept 1
      '{32'h0000_0005, 32'h0000_0025},  // R2 clear flag, R4 readback
      '{32'h8000_0002, 32'h0000_0022},  // R2 writing 1 leaves flag clear
      '{32'h7FFF_FFF8, 32'h0000_0020},  // R8 unimplemented ones ignored
      '{32'hFFFF_FFFF, 32'h0000_0027},  // R6 R8 status/unused ignore writes
      '{32'h0000_0003, 32'h0000_0023}   // R4
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic idle(input int n);
      @(negedge tck); up_dr = 1'b0;
      repeat (n) @(negedge tck);
   endtask

   // Capture, 32 shifts, Update; the next scan may start on the following TCK
   task automatic scan(input logic [31:0] w, output logic [31:0] cap);
      @(negedge tck); up_dr = 1'b0; cap_dr = 1'b1;
      for (int i = 0; i < 32; i++) begin
         @(negedge tck);
         cap_dr = 1'b0; sh_dr = 1'b1;
         cap[i] = tdo;
         tdi = w[i];
      end
      @(negedge tck); sh_dr = 1'b0; up_dr = 1'b1;
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      logic [31:0] c;
      trst_n = 0; sel = 1; cap_dr = 0; sh_dr = 0; up_dr = 0; tdi = 0;
      cpu_rst_n = 0; dm = 0; lp = 1;
      repeat (4) @(negedge tck);
      trst_n = 1; cpu_rst_n = 1;
      idle(10);
      chk("R1 ctl_o after reset", {29'b0, ctl}, 32'h0);

      // vector walk: each scan captures the result of the previous write
      scan(TBL[0].wr, c);
      chk("R1 R7 first capture", c, 32'h8000_0020);
      for (int i = 0; i < NV; i++) begin
         scan((i + 1 < NV) ? TBL[i+1].wr : 32'h0000_0003, c);
         chk($sformatf("R4 back-to-back vector %0d", i), c, TBL[i].rd);
      end
      idle(30);
      chk("R5 ctl_o follows shadow", {29'b0, ctl}, 32'h3);

      // status capture
      dm = 1; lp = 0;
      idle(6);
      scan(32'h0000_0003, c);
      chk("R6 status bits", c, 32'h0000_0013);

      // processor reset
      cpu_rst_n = 0;
      idle(10);
      chk("R5 ctl_o in cpu reset", {29'b0, ctl}, 32'h0);
      scan(32'h0000_0007, c);
      chk("R9 wiped during reset", c, 32'h8000_0010);
      scan(32'h0000_0000, c);
      chk("R2 R9 flag held, write lost", c, 32'h8000_0010);
      cpu_rst_n = 1;
      idle(10);
      scan(32'h8000_0001, c);
      chk("R2 flag sticky after release", c, 32'h8000_0010);
      scan(32'h0000_0001, c);
      chk("R3 refused after reset", c, 32'h8000_0010);
      scan(32'h0000_0001, c);
      chk("R4 accepted after ack", c, 32'h0000_0011);
      idle(30);
      chk("R5 ctl_o after reacknowledge", {29'b0, ctl}, 32'h1);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge tck);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end
endmodule